// File: doc/BRIEF.md
# UART Transmitter with Break-Field Generator

This block is the transmit half of a UART aimed at LIN-style single-wire buses. It serialises bytes as plain 8N1 frames. On request it sends a synchronisation break instead: the line is held low for a programmable 13 to 20 bit times, then one high stop bit follows. An external baud generator supplies a single-cycle bit tick once per bit period, and every change on the line happens on a clock edge where that tick is high.

Software starts a break by pulsing a trigger input. The trigger status bit stays set from that pulse until the break's stop bit has finished, so it can be polled to see when the break is complete. Every break and every data frame raises a one-cycle transmit interrupt as it begins. One byte can be queued while the line is busy, and it goes out immediately after the current stop bit. The transmitter works only while both the power enable and the transmit enable are high. Dropping either one aborts any activity and discards pending work.

Top module: `uart_brk_tx`

## Requirements
- R1: While `pwr_on` or `tx_on` is low, `txd` is 1, `tx_busy`, `tx_irq` and `brk_active` are 0, and any byte write or trigger pulse in that time is discarded. Nothing from it is sent after re-enabling.
- R2: When enabled with no queued byte and no trigger set, `txd` stays 1 and no interrupt occurs.
- R3: A data frame is one low start bit, then the 8 data bits with bit 0 first, then one high stop bit. Each bit lasts one bit-tick period, and `txd` changes only on clock edges where `bit_tick` is high.
- R4: A break holds `txd` low for 13 + `brk_len_sel` bit periods. The encoding is 0 -> 13 and 7 -> 20. The select value is taken when the break starts, so later changes do not alter it. One high stop bit follows the low period.
- R5: `tx_irq` is high for exactly one clock cycle at the start of every break and every data frame, in the cycle where `txd` first goes low. It never pulses otherwise.
- R6: A `brk_go` pulse while enabled and not busy sets `brk_active`. It clears when the break's stop bit ends.
- R7: A `brk_go` pulse while `tx_busy` is high is ignored: `brk_active` stays 0 and no break follows.
- R8: A byte written while busy is held and sent starting on the tick that ends the current stop bit, with no idle bit between. A second write before that replaces the held byte.
- R9: `tx_busy` rises with the first low bit of a break or frame. It falls when the stop bit ends, unless another break or frame starts on that same tick.
- R10: If a trigger and a byte are both waiting when a transmission can start, the break goes first and the byte follows right after the break's stop bit.
- R11: During reset `txd` is 1 and `tx_busy`, `tx_irq` and `brk_active` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Power enable for the transmitter |
| tx_on | input | 1 | Transmit enable |
| bit_tick | input | 1 | One-cycle pulse, once per bit period |
| wr_stb | input | 1 | One-cycle byte write strobe |
| wr_byte | input | 8 | Byte to send |
| brk_go | input | 1 | One-cycle break trigger pulse |
| brk_len_sel | input | 3 | Break length select, length = 13 + value |
| txd | output | 1 | Serial transmit line, idles high |
| tx_irq | output | 1 | One-cycle pulse at the start of each break or frame |
| tx_busy | output | 1 | Break or frame in progress |
| brk_active | output | 1 | Break trigger status, self-clearing |

## Verification
The hardest situations to create from the ports are those where two launch sources meet the tick that ends a stop bit. One is a byte queued during a break, which must leave on the very tick that ends the break's stop bit. The other is a trigger and a byte arriving together while idle, which tests the ordering between them. The stimulus produces both cases directly. It pulses `brk_go` and `wr_stb` in the same cycle between ticks, and it writes bytes, sometimes twice, just after a start bit has been checked. Seeded random sequences of frames, breaks with every length select and back-to-back pairs then exercise the same paths with varied data.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_BRK   = 3'd1,
      ST_START = 3'd2,
      ST_DATA  = 3'd3,
      ST_STOP  = 3'd4
   } tx_state_t;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/utx_hold_buf.sv
module utx_hold_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              vld,
   output logic [DATA_W-1:0] data
);

   if (DATA_W < 1) begin : g_bad_width
      $error("utx_hold_buf: DATA_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         data <= '0;
      end else if (!en) begin
         vld  <= 1'b0;
      end else begin
         if (wr_stb) begin
            vld  <= 1'b1;
            data <= wr_data;
         end else if (take) begin
            vld  <= 1'b0;
         end
      end
   end

   // the sequencer may only pop a byte that is actually held
   assert_take_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> vld);

   // disabling drops the held byte
   assert_drop_on_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !vld);

endmodule

// File: rtl/utx_brk_trig.sv
module utx_brk_trig (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic brk_go,
   input  logic busy,
   input  logic brk_done,
   output logic trig
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig <= 1'b0;
      end else if (!en) begin
         trig <= 1'b0;
      end else if (brk_done) begin
         trig <= 1'b0;
      end else if (brk_go && !busy) begin
         trig <= 1'b1;
      end
   end

   // a trigger pulse during a frame must not arm a break
   assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && busy && !trig) |=> !trig);

   // finishing the break stop bit clears the status
   assert_self_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      brk_done |=> !trig);

   assert_off_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !trig);

endmodule

// File: rtl/utx_seq.sv
module utx_seq
   import uart_brk_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SEL_W     = 3,
   parameter int BRK_MIN   = 13,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              brk_req,
   input  logic              buf_vld,
   input  logic [DATA_W-1:0] buf_data,
   input  logic [SEL_W-1:0]  sel,
   output logic              txd,
   output logic              irq,
   output logic              busy,
   output logic              take,
   output logic              brk_done
);

   localparam int BRK_MAX = BRK_MIN + (1 << SEL_W) - 1;
   localparam int CNT_W   = $clog2(max_int(BRK_MAX, DATA_W) + 1);

   if (DATA_W < 2) begin : g_bad_data
      $error("utx_seq: DATA_W must be at least 2");
   end
   if (BRK_MIN < 2) begin : g_bad_brk
      $error("utx_seq: BRK_MIN must be at least 2");
   end
   if (SEL_W < 1 || SEL_W > 6) begin : g_bad_sel
      $error("utx_seq: SEL_W out of range");
   end

   tx_state_t         st_q, st_n;
   logic [CNT_W-1:0]  cnt_q, cnt_n;
   logic [DATA_W-1:0] sh_q, sh_n;
   logic              txd_q, txd_n;
   logic              brk_q, brk_n;
   logic              irq_q;
   logic              bit_out;
   logic [DATA_W-1:0] sh_adv;
   logic              can_launch, go_brk, go_dat, frame_end;

   // serial order variant
   if (LSB_FIRST) begin : g_lsb
      assign bit_out = sh_q[0];
      assign sh_adv  = {1'b0, sh_q[DATA_W-1:1]};
   end else begin : g_msb
      assign bit_out = sh_q[DATA_W-1];
      assign sh_adv  = {sh_q[DATA_W-2:0], 1'b0};
   end

   assign frame_end  = tick && (st_q == ST_STOP);
   assign brk_done   = frame_end && brk_q;
   assign can_launch = en && tick && ((st_q == ST_IDLE) || (st_q == ST_STOP));
   assign go_brk     = can_launch && brk_req && !brk_done;
   assign go_dat     = can_launch && !go_brk && buf_vld;
   assign take       = go_dat;

   always_comb begin
      st_n  = st_q;
      cnt_n = cnt_q;
      sh_n  = sh_q;
      txd_n = txd_q;
      brk_n = brk_q;
      if (go_brk) begin
         st_n  = ST_BRK;
         cnt_n = CNT_W'(BRK_MIN - 1) + CNT_W'(sel);
         txd_n = 1'b0;
         brk_n = 1'b1;
      end else if (go_dat) begin
         st_n  = ST_START;
         sh_n  = buf_data;
         txd_n = 1'b0;
         brk_n = 1'b0;
      end else if (tick) begin
         case (st_q)
            ST_BRK: begin
               if (cnt_q == '0) begin
                  st_n  = ST_STOP;
                  txd_n = 1'b1;
               end else begin
                  cnt_n = cnt_q - 1'b1;
               end
            end
            ST_START: begin
               txd_n = bit_out;
               sh_n  = sh_adv;
               cnt_n = CNT_W'(DATA_W - 1);
               st_n  = ST_DATA;
            end
            ST_DATA: begin
               if (cnt_q == '0) begin
                  st_n  = ST_STOP;
                  txd_n = 1'b1;
               end else begin
                  txd_n = bit_out;
                  sh_n  = sh_adv;
                  cnt_n = cnt_q - 1'b1;
               end
            end
            ST_STOP: begin
               st_n  = ST_IDLE;
               txd_n = 1'b1;
               brk_n = 1'b0;
            end
            default: begin
               st_n  = ST_IDLE;
               txd_n = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         sh_q  <= '0;
         txd_q <= 1'b1;
         brk_q <= 1'b0;
         irq_q <= 1'b0;
      end else if (!en) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         txd_q <= 1'b1;
         brk_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         st_q  <= st_n;
         cnt_q <= cnt_n;
         sh_q  <= sh_n;
         txd_q <= txd_n;
         brk_q <= brk_n;
         irq_q <= go_brk || go_dat;
      end
   end

   assign txd  = txd_q;
   assign irq  = irq_q;
   assign busy = (st_q != ST_IDLE);

   // idle line is high
   assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   // interrupt marks the first low bit of a launch on a tick
   assert_irq_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!txd && busy && $past(tick)));

   assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // line only moves on a tick edge while enabled
   assert_tick_paced_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !$past(tick)) |-> $stable(txd));

   // break stop bit is high
   assert_brk_stop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      brk_done |-> txd);

   assert_brk_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BRK) |-> (cnt_q <= CNT_W'(BRK_MAX - 1)));

   // disable forces the idle line
   assert_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> (txd && !busy && !irq));

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
   parameter int DATA_W    = 8,
   parameter int SEL_W     = 3,
   parameter int BRK_MIN   = 13,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_on,
   input  logic              tx_on,
   input  logic              bit_tick,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              brk_go,
   input  logic [SEL_W-1:0]  brk_len_sel,
   output logic              txd,
   output logic              tx_irq,
   output logic              tx_busy,
   output logic              brk_active
);

   logic              en;
   logic              buf_vld;
   logic [DATA_W-1:0] buf_data;
   logic              take;
   logic              brk_done;
   logic              trig;

   assign en = pwr_on && tx_on;

   utx_hold_buf #(.DATA_W(DATA_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .wr_stb  (wr_stb),
      .wr_data (wr_byte),
      .take    (take),
      .vld     (buf_vld),
      .data    (buf_data)
   );

   utx_brk_trig u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .brk_go   (brk_go),
      .busy     (tx_busy),
      .brk_done (brk_done),
      .trig     (trig)
   );

   utx_seq #(
      .DATA_W    (DATA_W),
      .SEL_W     (SEL_W),
      .BRK_MIN   (BRK_MIN),
      .LSB_FIRST (LSB_FIRST)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .tick     (bit_tick),
      .brk_req  (trig),
      .buf_vld  (buf_vld),
      .buf_data (buf_data),
      .sel      (brk_len_sel),
      .txd      (txd),
      .irq      (tx_irq),
      .busy     (tx_busy),
      .take     (take),
      .brk_done (brk_done)
   );

   assign brk_active = trig;

   // a break never starts without its status bit set
   assert_brk_needs_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_irq && !$past(buf_vld)) |-> brk_active);

endmodule

// File: tb/uart_brk_tx_tb.sv
module uart_brk_tx_tb;

   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_on = 1'b1;
   logic       tx_on = 1'b1;
   logic       bit_tick = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_byte = 8'h00;
   logic       brk_go = 1'b0;
   logic [2:0] brk_len_sel = 3'd0;
   logic       txd, tx_irq, tx_busy, brk_active;

   int checks = 0;
   int fails = 0;
   int irq_seen = 0;
   int launches = 0;
   int tcnt = 0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      tcnt     <= (tcnt == DIV - 1) ? 0 : tcnt + 1;
      bit_tick <= (tcnt == DIV - 1);
   end

   always @(negedge clk) if (rst_n && tx_irq) irq_seen++;

   uart_brk_tx u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .tx_on(tx_on),
      .bit_tick(bit_tick), .wr_stb(wr_stb), .wr_byte(wr_byte),
      .brk_go(brk_go), .brk_len_sel(brk_len_sel), .txd(txd),
      .tx_irq(tx_irq), .tx_busy(tx_busy), .brk_active(brk_active)
   );

   function automatic logic frame_bit(input logic [7:0] b, input int i);
      if (i == 0) return 1'b0;
      if (i <= 8) return b[i-1];
      return 1'b1;
   endfunction

   function automatic int brk_len(input logic [2:0] s);
      return 13 + int'(s);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic next_tick();
      while (!bit_tick) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_wr(input logic [7:0] b);
      wr_byte = b; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic pulse_brk();
      brk_go = 1'b1;
      @(negedge clk);
      brk_go = 1'b0;
   endtask

   // mid: 0 none, 1 queue nb, 2 queue junk then nb, 3 trigger while busy
   task automatic exp_frame(input logic [7:0] b, input int mid, input logic [7:0] nb);
      next_tick();
      launches++;
      chk("R3", "start bit", txd, 0);
      chk("R5", "irq at frame start", tx_irq, 1);
      chk("R9", "busy at start", tx_busy, 1);
      if (mid == 1) pulse_wr(nb);
      if (mid == 2) begin pulse_wr(~nb); pulse_wr(nb); end
      if (mid == 3) begin
         pulse_brk();
         chk("R7", "trigger ignored while busy", brk_active, 0);
      end
      for (int i = 1; i <= 8; i++) begin
         next_tick();
         chk("R3", $sformatf("data bit %0d", i - 1), txd, frame_bit(b, i));
      end
      next_tick();
      chk("R3", "stop bit", txd, 1);
      chk("R9", "busy in stop", tx_busy, 1);
   endtask

   task automatic exp_break(input logic [2:0] s, input logic [7:0] qb, input bit queue);
      int n = brk_len(s);
      next_tick();
      launches++;
      chk("R4", "break first low", txd, 0);
      chk("R5", "irq at break start", tx_irq, 1);
      brk_len_sel = ~s;
      if (queue) pulse_wr(qb);
      for (int i = 1; i < n; i++) begin
         next_tick();
         chk("R4", $sformatf("break low period %0d of %0d", i + 1, n), txd, 0);
      end
      next_tick();
      chk("R4", "break stop high", txd, 1);
      chk("R6", "status held through stop", brk_active, 1);
   endtask

   task automatic exp_end();
      next_tick();
      chk("R9", "busy falls after stop", tx_busy, 0);
      chk("R2", "line idle high", txd, 1);
      chk("R6", "status cleared", brk_active, 0);
   endtask

   task automatic start_break(input logic [2:0] s);
      brk_len_sel = s;
      pulse_brk();
      chk("R6", "status set by trigger", brk_active, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "txd in reset", txd, 1);
      chk("R11", "busy in reset", tx_busy, 0);
      chk("R11", "irq in reset", tx_irq, 0);
      chk("R11", "status in reset", brk_active, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 idle with nothing to do
      for (int i = 0; i < 12; i++) begin
         next_tick();
         chk("R2", "idle line", txd, 1);
      end
      chk("R2", "no irq while idle", irq_seen, 0);

      // R3 directed frames
      pulse_wr(8'hA5); exp_frame(8'hA5, 0, 8'h00); exp_end();
      pulse_wr(8'h00); exp_frame(8'h00, 0, 8'h00); exp_end();
      pulse_wr(8'hFF); exp_frame(8'hFF, 0, 8'h00); exp_end();

      // R4 shortest and longest break
      start_break(3'd0); exp_break(3'd0, 8'h00, 0); exp_end();
      start_break(3'd7); exp_break(3'd7, 8'h00, 0); exp_end();

      // R8 back-to-back and overwrite
      pulse_wr(8'h3C); exp_frame(8'h3C, 1, 8'hC3);
      exp_frame(8'hC3, 2, 8'h5A);
      exp_frame(8'h5A, 0, 8'h00); exp_end();

      // R7 trigger while busy, no break afterward
      pulse_wr(8'h81); exp_frame(8'h81, 3, 8'h00); exp_end();
      for (int i = 0; i < 4; i++) begin
         next_tick();
         chk("R7", "no break after ignored trigger", txd, 1);
      end

      // R10 trigger and byte together: break first, byte right after
      brk_len_sel = 3'd2;
      brk_go = 1'b1; wr_byte = 8'h96; wr_stb = 1'b1;
      @(negedge clk);
      brk_go = 1'b0; wr_stb = 1'b0;
      exp_break(3'd2, 8'h00, 0);
      exp_frame(8'h96, 0, 8'h00);
      chk("R10", "status clear after break", brk_active, 0);
      exp_end();

      // R8 byte queued during a break follows immediately
      start_break(3'd5); exp_break(3'd5, 8'h4E, 1);
      exp_frame(8'h4E, 0, 8'h00); exp_end();

      // R1 disable mid frame and ignore requests while off
      pulse_wr(8'h77);
      next_tick(); launches++;
      next_tick(); next_tick();
      tx_on = 1'b0;
      @(negedge clk);
      chk("R1", "txd forced high", txd, 1);
      chk("R1", "busy cleared", tx_busy, 0);
      pulse_wr(8'h12); pulse_brk();
      chk("R1", "trigger ignored when off", brk_active, 0);
      tx_on = 1'b1;
      start_break(3'd1);
      pwr_on = 1'b0;
      @(negedge clk);
      chk("R1", "power off clears status", brk_active, 0);
      pwr_on = 1'b1;
      for (int i = 0; i < 14; i++) begin
         next_tick();
         chk("R1", "nothing sent after re-enable", txd, 1);
      end

      // seeded random mix
      for (int it = 0; it < 30; it++) begin
         int op = int'($urandom % 3);
         logic [7:0] b1 = 8'($urandom);
         logic [7:0] b2 = 8'($urandom);
         logic [2:0] s = 3'($urandom);
         if (op == 0) begin
            pulse_wr(b1); exp_frame(b1, 0, 8'h00); exp_end();
         end else if (op == 1) begin
            start_break(s); exp_break(s, 8'h00, 0); exp_end();
         end else begin
            pulse_wr(b1); exp_frame(b1, 1, b2);
            exp_frame(b2, 0, 8'h00); exp_end();
         end
      end

      chk("R5", "total irq pulses", irq_seen, launches);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule